// File: doc/BRIEF.md
# Chainable Active-Low Priority Encoder, 32 Requests

The block takes a vector of 32 request lines. It returns the position of the highest-numbered request that is asserted. A separate flag tells a valid result apart from an idle input.

All pins are active-low: requests, index, enable, the group flag and the chain output. An 8-input slice is the basic cell. Each slice has an enable input and a chain-enable output. The chain-enable output is asserted only when the slice is enabled and sees no request, so it can switch on the next lower slice. The top level links four slices in this way, with the highest group at the head of the chain.

The upper two index bits name the slice that found a request. The lower three bits are the merged codes of all slices, which works because every idle or disabled slice drives an all-high code. The design is purely combinational and has no storage.

Top module: `pe32_cascade`

## Requirements
- R1: While `en_n` is high, `idx_n` is all ones, and `gs_n` and `eo_n` are both high, whatever the requests are.
- R2: While `en_n` is low and every bit of `req_n` is high, `idx_n` is all ones, `gs_n` is high and `eo_n` is low.
- R3: While `en_n` is low and at least one bit of `req_n` is low, `gs_n` is low and `eo_n` is high. `gs_n` and `eo_n` are never low together.
- R4: While enabled, the bitwise inverse of `idx_n` equals the number of the highest-numbered low bit of `req_n`. Bit 31 has top priority and bit 0 the lowest.
- R5: Lower-numbered requests have no effect on `idx_n` while a higher-numbered request is asserted.
- R6: When requests fall in several 8-bit groups, the inverse of `idx_n[4:3]` names the highest such group, and the inverse of `idx_n[2:0]` is the position within that group only.
- R7: A lone request on bit 0 and no request at all both give `idx_n` all ones. The two cases differ only in `gs_n` (low versus high) and `eo_n` (high versus low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_n | input | 32 | Request lines, low means asserted |
| en_n | input | 1 | Enable, low means the encoder works |
| idx_n | output | 5 | Inverted number of the winning request |
| gs_n | output | 1 | Low when a request was found |
| eo_n | output | 1 | Low when enabled and no request is present, for chaining |

## Verification
Two functions can act in the same evaluation: the chain that enables a lower slice, and the merge of the slices' codes into one index. Patterns with requests in two or more groups at once (for example bits 16, 8 and 0) provoke both. They are judged by checking that the result takes its group and its low bits from the highest group alone. A behavioural highest-set-bit search, walked from bit 0 upward, gives the expected index for the one-hot, empty and random patterns, with the enable both asserted and deasserted.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int MAX_W  = 64;
  localparam int MAX_IW = 6;

  typedef struct packed {
    logic              hit;
    logic [MAX_IW-1:0] idx;
  } pe_hit_t;

  // highest set bit of a vector, searched from the top down
  function automatic pe_hit_t top_set(input logic [MAX_W-1:0] v);
    pe_hit_t r;
    r.hit = 1'b0;
    r.idx = '0;
    for (int i = MAX_W - 1; i >= 0; i--) begin
      if (v[i] && !r.hit) begin
        r.hit = 1'b1;
        r.idx = MAX_IW'(i);
      end
    end
    return r;
  endfunction

  // OR-reduce a set of inverted code words, column by column
  function automatic logic [MAX_IW-1:0] or_words(input logic [MAX_W-1:0][MAX_IW-1:0] w,
                                                 input int n);
    logic [MAX_IW-1:0] acc;
    acc = '0;
    for (int k = 0; k < MAX_W; k++) begin
      if (k < n) acc = acc | w[k];
    end
    return acc;
  endfunction
endpackage

// File: rtl/pe_slice.sv
module pe_slice #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_n,
  input  logic          en_n,
  output logic [IW-1:0] code_n,
  output logic          gs_n,
  output logic          eo_n
);
  logic [pe_pkg::MAX_W-1:0] req_hi;
  pe_pkg::pe_hit_t          found;
  logic                     slice_on;
  logic                     any_req;
  logic [IW-1:0]            hit_idx;

  always_comb begin
    req_hi   = '0;
    req_hi[W-1:0] = ~req_n;
    found    = pe_pkg::top_set(req_hi);
    slice_on = ~en_n;
    any_req  = found.hit;
    hit_idx  = found.idx[IW-1:0];
  end

  assign code_n = (slice_on && any_req) ? ~hit_idx : '1;
  assign gs_n   = ~(slice_on && any_req);
  assign eo_n   = ~(slice_on && !any_req);

  // checks against the slice pins
  always_comb begin
    if (en_n) begin
      p_slice_quiet_r1: assert (code_n == '1 && gs_n && eo_n)
        else $error("R1 slice disabled but an output is active");
    end
    p_slice_excl_r3: assert (gs_n || eo_n)
      else $error("R3 slice gs_n and eo_n low together");
    if (!en_n && &req_n) begin
      p_slice_idle_r2: assert (!eo_n && code_n == '1)
        else $error("R2 idle slice did not pass the enable on");
    end
  end
endmodule

// File: rtl/pe_merge.sv
module pe_merge #(
  parameter int N  = 4,
  parameter int IW = 3,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0][IW-1:0] code_n,
  input  logic [N-1:0]         gs_n,
  output logic [SW+IW-1:0]     idx_n,
  output logic                 gs_all_n
);
  logic [pe_pkg::MAX_W-1:0]                   grp_hi;
  logic [pe_pkg::MAX_W-1:0][pe_pkg::MAX_IW-1:0] words;
  pe_pkg::pe_hit_t                            grp;
  logic [pe_pkg::MAX_IW-1:0]                  low_or;
  logic [SW-1:0]                              grp_sel;
  logic [IW-1:0]                              low_bits;

  always_comb begin
    grp_hi = '0;
    words  = '0;
    for (int k = 0; k < N; k++) begin
      grp_hi[k]         = ~gs_n[k];
      words[k][IW-1:0]  = ~code_n[k];
    end
    grp      = pe_pkg::top_set(grp_hi);
    low_or   = pe_pkg::or_words(words, N);
    grp_sel  = grp.idx[SW-1:0];
    low_bits = low_or[IW-1:0];
  end

  assign idx_n    = ~{grp_sel, low_bits};
  assign gs_all_n = &gs_n;

  // the chain must never leave two groups active
  always_comb begin
    p_one_group_r6: assert ($onehot0(~gs_n))
      else $error("R6 more than one slice claims a request");
  end
endmodule

// File: rtl/pe32_cascade.sv
module pe32_cascade #(
  parameter int SLICE_W  = 8,
  parameter int N_SLICES = 4,
  parameter int IW       = $clog2(SLICE_W),
  parameter int SW       = $clog2(N_SLICES),
  parameter int REQ_W    = SLICE_W * N_SLICES
) (
  input  logic [REQ_W-1:0]  req_n,
  input  logic              en_n,
  output logic [SW+IW-1:0]  idx_n,
  output logic              gs_n,
  output logic              eo_n
);
  logic [N_SLICES-1:0]          en_n_s;
  logic [N_SLICES-1:0]          eo_n_s;
  logic [N_SLICES-1:0]          gs_n_s;
  logic [N_SLICES-1:0][IW-1:0]  code_n_s;

  // highest group heads the chain; each idle slice enables the one below
  assign en_n_s[N_SLICES-1] = en_n;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    if (k < N_SLICES - 1) begin : g_link
      assign en_n_s[k] = eo_n_s[k+1];
    end
    pe_slice #(.W(SLICE_W), .IW(IW)) u_slice (
      .req_n  (req_n[k*SLICE_W +: SLICE_W]),
      .en_n   (en_n_s[k]),
      .code_n (code_n_s[k]),
      .gs_n   (gs_n_s[k]),
      .eo_n   (eo_n_s[k])
    );
  end

  pe_merge #(.N(N_SLICES), .IW(IW), .SW(SW)) u_merge (
    .code_n   (code_n_s),
    .gs_n     (gs_n_s),
    .idx_n    (idx_n),
    .gs_all_n (gs_n)
  );

  assign eo_n = eo_n_s[0];

  always_comb begin
    if (en_n) begin
      p_top_quiet_r1: assert (idx_n == '1 && gs_n && eo_n)
        else $error("R1 encoder disabled but an output is active");
    end
    if (!en_n && &req_n) begin
      p_top_idle_r2: assert (!eo_n && gs_n)
        else $error("R2 idle encoder did not signal empty");
    end
    if (!en_n && !(&req_n)) begin
      p_top_found_r3: assert (!gs_n && eo_n)
        else $error("R3 request present but not flagged");
    end
    if (!en_n && !req_n[REQ_W-1]) begin
      p_top_prio_r5: assert (idx_n == '0)
        else $error("R5 top request did not win");
    end
  end
endmodule

// File: tb/pe32_cascade_tb_top.sv
module pe32_cascade_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] req_n;
  logic        en_n;
  logic [4:0]  idx_n;
  logic        gs_n;
  logic        eo_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  pe32_cascade dut_i (
    .req_n (req_n),
    .en_n  (en_n),
    .idx_n (idx_n),
    .gs_n  (gs_n),
    .eo_n  (eo_n)
  );

  // {requests active-high, enable active-high, expected index, found, empty}
  typedef struct packed {
    logic [31:0] req;
    logic        en;
    logic [4:0]  idx;
    logic        found;
    logic        empty;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TABLE [NV] = '{
    '{32'h0000_0000, 1'b1, 5'd0,  1'b0, 1'b1},  // R2
    '{32'h0000_0001, 1'b1, 5'd0,  1'b1, 1'b0},  // R7
    '{32'h8000_0000, 1'b1, 5'd31, 1'b1, 1'b0},  // R4
    '{32'h0000_0100, 1'b1, 5'd8,  1'b1, 1'b0},  // R4
    '{32'h0000_00FF, 1'b1, 5'd7,  1'b1, 1'b0},  // R5
    '{32'h0001_0101, 1'b1, 5'd16, 1'b1, 1'b0},  // R6
    '{32'h0F0F_0000, 1'b1, 5'd27, 1'b1, 1'b0},  // R6
    '{32'h0080_0001, 1'b1, 5'd23, 1'b1, 1'b0},  // R6
    '{32'hFFFF_FFFF, 1'b0, 5'd0,  1'b0, 1'b0},  // R1
    '{32'h0000_0001, 1'b0, 5'd0,  1'b0, 1'b0}   // R1
  };

  // reference: walk upward, the last set bit seen wins
  task automatic model(input logic [31:0] req, input logic en,
                       output logic [4:0] i, output logic f, output logic e);
    i = 5'd0; f = 1'b0;
    for (int b = 0; b < 32; b++) begin
      if (req[b]) begin i = 5'(b); f = 1'b1; end
    end
    if (!en) begin i = 5'd0; f = 1'b0; e = 1'b0; end
    else e = !f;
  endtask

  task automatic apply_and_check(input logic [31:0] req, input logic en,
                                 input logic [4:0] ei, input logic ef, input logic ee,
                                 input string tag);
    @(posedge clk);
    req_n = ~req;
    en_n  = ~en;
    @(negedge clk);
    checks++;
    if (idx_n !== ~ei || gs_n !== ~ef || eo_n !== ~ee) begin
      errors++;
      $display("FAIL %s req=%h en=%0b got idx_n=%b gs_n=%b eo_n=%b exp idx_n=%b gs_n=%b eo_n=%b",
               tag, req, en, idx_n, gs_n, eo_n, ~ei, ~ef, ~ee);
    end
  endtask

  task automatic check_model(input logic [31:0] req, input logic en, input string tag);
    logic [4:0] i; logic f; logic e;
    model(req, en, i, f, e);
    apply_and_check(req, en, i, f, e, tag);
  endtask

  initial begin
    req_n = '1;
    en_n  = 1'b1;
    // start-up state with the block disabled (R1)
    @(negedge clk);
    checks++;
    if (idx_n !== 5'h1F || gs_n !== 1'b1 || eo_n !== 1'b1) begin
      errors++;
      $display("FAIL R1 initial idx_n=%b gs_n=%b eo_n=%b exp 11111 1 1", idx_n, gs_n, eo_n);
    end

    for (int v = 0; v < NV; v++)
      apply_and_check(TABLE[v].req, TABLE[v].en, TABLE[v].idx,
                      TABLE[v].found, TABLE[v].empty, "R4 table");

    // one-hot sweep, both enable levels (R4, R1)
    for (int b = 0; b < 32; b++) begin
      check_model(32'h1 << b, 1'b1, "R4 onehot");
      check_model(32'h1 << b, 1'b0, "R1 onehot disabled");
    end
    // a top bit plus all lower bits (R5)
    for (int b = 0; b < 32; b++)
      check_model(32'hFFFF_FFFF >> (31 - b), 1'b1, "R5 fill");
    // bit 0 against empty (R7)
    check_model(32'h0, 1'b1, "R7 empty");
    check_model(32'h1, 1'b1, "R7 bit0");
    // multi-group patterns (R6)
    for (int g = 0; g < 4; g++)
      check_model((32'h0101_0101 >> (8 * g)) | 32'h1, 1'b1, "R6 groups");
    // random patterns, sparse and dense (R3, R4)
    for (int n = 0; n < 10000; n++) begin
      logic [31:0] r;
      r = $urandom();
      if (n % 3 == 0) r = r & $urandom() & $urandom() & $urandom();
      check_model(r, (n % 5) != 0, "R3 random");
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule